// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home node for a group of memory lines in a shared-memory system that keeps caches coherent without broadcasting. For each line it owns, it holds a directory entry with three parts: a line state (Invalid, Shared or Modified), the number of the node that owns a dirty copy, and a one-bit-per-node vector of the nodes that hold the line. Nodes send it read and read-exclusive requests. It answers with fills. Where other nodes hold the line, it first sends invalidate or fetch probes to exactly those nodes, and it counts their acknowledgements before the fill goes out.

The network is modelled as per-node channels. Each node has a request channel (valid, exclusive flag, line number) with a ready back from the home. Each node also has a one-bit acknowledgement input. A response vector carries one valid bit per node, together with a shared response kind and line number. The controller serves one transaction at a time. Requests that arrive while a transaction is open are held off until it finishes. Among nodes that request together, the lowest-numbered node wins.

Top module: `hd_home_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, no response is valid. After reset every line is Invalid, so the first access to any line gets its fill with no probe beforehand.
- R2: When no transaction is open, req_ready is driven high in the same cycle for the single lowest-numbered node whose req_valid is high, and for no other node. That request is taken at the next rising clock edge.
- R3: A read (req_excl=0) to a line that is not Modified answers in the cycle after acceptance. It raises rsp_valid for the requester only, with rsp_kind 0 (fill-shared) and rsp_line equal to the requested line. The requester is then recorded as a sharer.
- R4: A read-exclusive (req_excl=1) to a line held by other nodes produces a probe in the cycle after acceptance. The probe lasts one cycle, has rsp_kind 2 (invalidate), and has rsp_valid high for exactly those other holders: never for the requester and never for a node that does not hold the line.
- R5: An acknowledgement (ack_valid bit) counts only in the cycles after the probe, and only from a node that is still pending. Acknowledgements from any other node are ignored. The fill with rsp_kind 1 (fill-exclusive) reaches the requester in the cycle after the cycle in which the last pending acknowledgement arrives.
- R6: A read-exclusive to a line that no other node holds is answered with fill-exclusive in the cycle after acceptance, with no probe. This covers an Invalid line, and a line whose only holder is the requester.
- R7: A read to a line that another node holds Modified sends a one-cycle probe with rsp_kind 3 (fetch) to the owner only. After the owner acknowledges, the requester gets fill-shared, and the line becomes Shared with both nodes as holders.
- R8: After a read-exclusive completes, the line is Modified and the requester is its only holder. A later request from another node probes only that node.
- R9: From acceptance until the fill cycle ends, req_ready is low for every node. Requests held during that time are accepted afterwards, in the order given by R2.
- R10: Transactions to one line leave the directory entry of every other line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_NODES | Per-node request present |
| req_excl | input | N_NODES | Per-node request type: 1 read-exclusive, 0 read |
| req_line | input | N_NODES*LINE_W | Per-node line number, node k in bits [k*LINE_W +: LINE_W] |
| req_ready | output | N_NODES | Per-node request accepted at this edge |
| ack_valid | input | N_NODES | Per-node acknowledgement of an invalidate or fetch |
| rsp_valid | output | N_NODES | Per-node response present |
| rsp_kind | output | 2 | 0 fill-shared, 1 fill-exclusive, 2 invalidate, 3 fetch |
| rsp_line | output | LINE_W | Line the current response refers to |

## Verification
A directory entry that holds a wrong state, owner or sharer vector stays hidden until the next request to that line. It then shows up in the cycle after acceptance: a probe goes to the wrong set of nodes, or the probe is missing, or the fill has the wrong kind. The bench therefore revisits the same line from different nodes, and checks that unrelated lines stay undisturbed. A fault in the acknowledgement count shows up as a fill that comes one or more cycles too early or too late against the last acknowledgement. A fault in arbitration or hold-off shows up as a ready in the wrong cycle or to the wrong node. A cycle-by-cycle model catches each of these in the cycle it first appears.

// File: rtl/hd_pkg.sv
package hd_pkg;
  typedef enum logic [1:0] {
    DS_INVALID = 2'd0,
    DS_SHARED  = 2'd1,
    DS_MOD     = 2'd2
  } dir_state_t;

  typedef enum logic [1:0] {
    RK_FILL_SH = 2'd0,
    RK_FILL_EX = 2'd1,
    RK_INVAL   = 2'd2,
    RK_FETCH   = 2'd3
  } rsp_kind_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PROBE = 2'd1,
    PH_WAIT  = 2'd2,
    PH_FILL  = 2'd3
  } phase_t;
endpackage

// File: rtl/hd_pick_low.sv
module hd_pick_low #(
  parameter int N_NODES = 4,
  parameter int IDX_W   = $clog2(N_NODES)
) (
  input  logic [N_NODES-1:0] req,
  output logic [N_NODES-1:0] gnt,
  output logic [IDX_W-1:0]   idx,
  output logic               any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int k = N_NODES - 1; k >= 0; k--) begin
      if (req[k]) begin
        gnt    = '0;
        gnt[k] = 1'b1;
        idx    = IDX_W'(k);
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hd_dir_store.sv
module hd_dir_store
  import hd_pkg::*;
#(
  parameter int N_NODES = 4,
  parameter int N_LINES = 16,
  parameter int LINE_W  = $clog2(N_LINES),
  parameter int IDX_W   = $clog2(N_NODES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINE_W-1:0]  rd_line,
  output dir_state_t         rd_state,
  output logic [N_NODES-1:0] rd_holders,
  output logic [IDX_W-1:0]   rd_owner,
  input  logic               wr_en,
  input  logic [LINE_W-1:0]  wr_line,
  input  dir_state_t         wr_state,
  input  logic [N_NODES-1:0] wr_holders,
  input  logic [IDX_W-1:0]   wr_owner
);
  dir_state_t         st_a  [N_LINES];
  logic [N_NODES-1:0] hold_a[N_LINES];
  logic [IDX_W-1:0]   own_a [N_LINES];

  for (genvar e = 0; e < N_LINES; e++) begin : g_entry
    dir_state_t         st_q;
    logic [N_NODES-1:0] hold_q;
    logic [IDX_W-1:0]   own_q;
    logic               ent_en;

    assign ent_en = wr_en && (wr_line == LINE_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q   <= DS_INVALID;
        hold_q <= '0;
        own_q  <= '0;
      end else if (ent_en) begin
        st_q   <= wr_state;
        hold_q <= wr_holders;
        own_q  <= wr_owner;
      end
    end

    assign st_a[e]   = st_q;
    assign hold_a[e] = hold_q;
    assign own_a[e]  = own_q;
  end

  assign rd_state   = st_a[rd_line];
  assign rd_holders = hold_a[rd_line];
  assign rd_owner   = own_a[rd_line];
endmodule

// File: rtl/hd_ack_track.sv
module hd_ack_track #(
  parameter int N_NODES = 4,
  parameter int CNT_W   = $clog2(N_NODES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [N_NODES-1:0] load_mask,
  input  logic               collect,
  input  logic [N_NODES-1:0] ack,
  output logic [N_NODES-1:0] pend,
  output logic [CNT_W-1:0]   pend_cnt,
  output logic               last
);
  function automatic logic [CNT_W-1:0] popc(input logic [N_NODES-1:0] v);
    logic [CNT_W-1:0] s;
    s = '0;
    for (int k = 0; k < N_NODES; k++) s = s + CNT_W'(v[k]);
    return s;
  endfunction

  logic [N_NODES-1:0] pend_d;
  logic [CNT_W-1:0]   cnt_d;
  logic [N_NODES-1:0] taken;
  logic               upd_en;

  assign taken  = ack & pend;
  assign last   = collect && (pend_cnt == popc(taken));
  assign upd_en = load || collect;

  always_comb begin
    pend_d = pend;
    cnt_d  = pend_cnt;
    if (load) begin
      pend_d = load_mask;
      cnt_d  = popc(load_mask);
    end else if (collect) begin
      pend_d = pend & ~taken;
      cnt_d  = pend_cnt - popc(taken);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= '0;
      pend_cnt <= '0;
    end else if (upd_en) begin
      pend     <= pend_d;
      pend_cnt <= cnt_d;
    end
  end
endmodule

// File: rtl/hd_home_ctrl.sv
module hd_home_ctrl
  import hd_pkg::*;
#(
  parameter int N_NODES = 4,
  parameter int N_LINES = 16,
  parameter int LINE_W  = $clog2(N_LINES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_NODES-1:0]          req_valid,
  input  logic [N_NODES-1:0]          req_excl,
  input  logic [N_NODES*LINE_W-1:0]   req_line,
  output logic [N_NODES-1:0]          req_ready,
  input  logic [N_NODES-1:0]          ack_valid,
  output logic [N_NODES-1:0]          rsp_valid,
  output logic [1:0]                  rsp_kind,
  output logic [LINE_W-1:0]           rsp_line
);
  localparam int IDX_W = $clog2(N_NODES);
  localparam int CNT_W = $clog2(N_NODES + 1);

  phase_t             ph_q, ph_d;
  logic [IDX_W-1:0]   node_q;
  logic               excl_q;
  logic [LINE_W-1:0]  line_q;
  rsp_kind_t          pkind_q, pkind_d;
  logic               cap_en;

  logic [N_NODES-1:0] gnt;
  logic [IDX_W-1:0]   pick_idx;
  logic               pick_any;
  logic [LINE_W-1:0]  pick_line;
  logic               pick_excl;

  logic [LINE_W-1:0]  rd_line;
  dir_state_t         rd_state;
  logic [N_NODES-1:0] rd_holders;
  logic [IDX_W-1:0]   rd_owner;
  logic               wr_en;
  dir_state_t         wr_state;
  logic [N_NODES-1:0] wr_holders;
  logic [IDX_W-1:0]   wr_owner;

  logic [N_NODES-1:0] others;
  logic [N_NODES-1:0] targets;
  logic               tr_load;
  logic               tr_collect;
  logic [N_NODES-1:0] pend;
  logic [CNT_W-1:0]   pend_cnt;
  logic               acks_done;
  logic [N_NODES-1:0] node_bit;

  hd_pick_low #(.N_NODES(N_NODES), .IDX_W(IDX_W)) i_pick (
    .req (req_valid),
    .gnt (gnt),
    .idx (pick_idx),
    .any (pick_any)
  );

  always_comb begin
    pick_line = '0;
    pick_excl = 1'b0;
    for (int k = 0; k < N_NODES; k++) begin
      if (gnt[k]) begin
        pick_line = req_line[k*LINE_W +: LINE_W];
        pick_excl = req_excl[k];
      end
    end
  end

  assign rd_line = (ph_q == PH_IDLE) ? pick_line : line_q;

  hd_dir_store #(
    .N_NODES(N_NODES), .N_LINES(N_LINES), .LINE_W(LINE_W), .IDX_W(IDX_W)
  ) i_dir (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_line    (rd_line),
    .rd_state   (rd_state),
    .rd_holders (rd_holders),
    .rd_owner   (rd_owner),
    .wr_en      (wr_en),
    .wr_line    (line_q),
    .wr_state   (wr_state),
    .wr_holders (wr_holders),
    .wr_owner   (wr_owner)
  );

  // Probe target selection for the request being accepted.
  assign others = rd_holders & ~gnt;
  always_comb begin
    targets = '0;
    pkind_d = RK_INVAL;
    if (pick_excl) begin
      targets = others;
      pkind_d = RK_INVAL;
    end else if (rd_state == DS_MOD) begin
      targets = others;
      pkind_d = RK_FETCH;
    end
  end

  assign cap_en     = (ph_q == PH_IDLE) && pick_any;
  assign tr_load    = cap_en && (targets != '0);
  assign tr_collect = (ph_q == PH_WAIT);

  hd_ack_track #(.N_NODES(N_NODES), .CNT_W(CNT_W)) i_acks (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (tr_load),
    .load_mask (targets),
    .collect   (tr_collect),
    .ack       (ack_valid),
    .pend      (pend),
    .pend_cnt  (pend_cnt),
    .last      (acks_done)
  );

  // Phase sequencing.
  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:  if (pick_any) ph_d = (targets != '0) ? PH_PROBE : PH_FILL;
      PH_PROBE: ph_d = PH_WAIT;
      PH_WAIT:  if (acks_done) ph_d = PH_FILL;
      PH_FILL:  ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      node_q  <= '0;
      excl_q  <= 1'b0;
      line_q  <= '0;
      pkind_q <= RK_INVAL;
    end else if (cap_en) begin
      node_q  <= pick_idx;
      excl_q  <= pick_excl;
      line_q  <= pick_line;
      pkind_q <= pkind_d;
    end
  end

  // Directory update in the fill cycle.
  always_comb begin
    node_bit         = '0;
    node_bit[node_q] = 1'b1;
  end

  assign wr_en = (ph_q == PH_FILL);
  always_comb begin
    if (excl_q) begin
      wr_state   = DS_MOD;
      wr_holders = node_bit;
      wr_owner   = node_q;
    end else begin
      wr_state   = DS_SHARED;
      wr_holders = rd_holders | node_bit;
      wr_owner   = rd_owner;
    end
  end

  // Outputs.
  assign req_ready = (ph_q == PH_IDLE) ? gnt : '0;
  assign rsp_line  = line_q;

  always_comb begin
    rsp_valid = '0;
    rsp_kind  = RK_FILL_SH;
    unique case (ph_q)
      PH_PROBE: begin
        rsp_valid = pend;
        rsp_kind  = pkind_q;
      end
      PH_FILL: begin
        rsp_valid = node_bit;
        rsp_kind  = excl_q ? RK_FILL_EX : RK_FILL_SH;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hd_home_chk.sv
module hd_home_chk #(
  parameter int N_NODES = 4,
  parameter int CNT_W   = $clog2(N_NODES + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_NODES-1:0] req_valid,
  input logic [N_NODES-1:0] req_ready,
  input logic [N_NODES-1:0] rsp_valid,
  input logic [1:0]         rsp_kind,
  input logic [N_NODES-1:0] pend,
  input logic [CNT_W-1:0]   pend_cnt
);
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> rsp_valid == '0);

  a_r2_single_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  a_r2_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  a_r9_hold_while_open: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid != '0 || pend != '0) |-> req_ready == '0);

  a_r3_fill_to_one: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid != '0 && rsp_kind[1] == 1'b0) |-> $onehot(rsp_valid));

  a_r4_probe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid != '0 && rsp_kind[1] == 1'b1) |=> rsp_valid == '0);

  a_r5_fill_after_acks: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid != '0 && rsp_kind == 2'd1) |-> pend_cnt == '0);

  a_r5_count_tracks_mask: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt == CNT_W'($countones(pend)));

  a_r7_fetch_to_one: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid != '0 && rsp_kind == 2'd3) |-> $onehot(rsp_valid));
endmodule

bind hd_home_ctrl hd_home_chk #(.N_NODES(N_NODES)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_kind  (rsp_kind),
  .pend      (pend),
  .pend_cnt  (pend_cnt)
);

// File: tb/test_hd_home_ctrl.sv
module test_hd_home_ctrl;
  localparam int NN = 4;
  localparam int NL = 16;
  localparam int LW = 4;

  logic              clk;
  logic              rst_n;
  logic [NN-1:0]     req_valid;
  logic [NN-1:0]     req_excl;
  logic [NN*LW-1:0]  req_line;
  logic [NN-1:0]     req_ready;
  logic [NN-1:0]     ack_valid;
  logic [NN-1:0]     rsp_valid;
  logic [1:0]        rsp_kind;
  logic [LW-1:0]     rsp_line;

  hd_home_ctrl #(.N_NODES(NN), .N_LINES(NL)) i_hd_home_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_excl(req_excl),
    .req_line(req_line), .req_ready(req_ready), .ack_valid(ack_valid),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_line(rsp_line)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk, n_fail, cycles;
  string tag;

  // Behavioural reference: 0 idle, 1 probe, 2 wait for acks, 3 fill.
  int m_ph, m_node, m_excl, m_line, m_kind, m_pend, m_wcnt;
  int d_st[NL];   // 0 invalid, 1 shared, 2 modified
  int d_hold[NL];
  int bogus;

  function automatic int lowbit(input int v);
    for (int k = 0; k < NN; k++) if (v[k]) return k;
    return -1;
  endfunction

  task automatic model_reset();
    m_ph = 0; m_pend = 0; m_wcnt = 0;
    for (int l = 0; l < NL; l++) begin d_st[l] = 0; d_hold[l] = 0; end
  endtask

  task automatic check();
    int e_rdy, e_rv, e_kind, e_line;
    bit bad;
    e_rdy = 0; e_rv = 0; e_kind = 0; e_line = m_line;
    if (rst_n && m_ph == 0 && req_valid != 0) e_rdy = 1 << lowbit(int'(req_valid));
    if (m_ph == 1) begin e_rv = m_pend; e_kind = m_kind; end
    if (m_ph == 3) begin e_rv = 1 << m_node; e_kind = m_excl ? 1 : 0; end
    bad = (int'(req_ready) != e_rdy) || (int'(rsp_valid) != e_rv);
    if (e_rv != 0 && (int'(rsp_kind) != e_kind || int'(rsp_line) != e_line)) bad = 1;
    n_chk++;
    if (bad) begin
      n_fail++;
      $display("FAIL %s cycle %0d: ready=%b valid=%b kind=%0d line=%0d, expected ready=%b valid=%b kind=%0d line=%0d",
               tag, cycles, req_ready, rsp_valid, rsp_kind, rsp_line,
               e_rdy[NN-1:0], e_rv[NN-1:0], e_kind, e_line);
    end
  endtask

  task automatic model_step();
    int n, others;
    if (!rst_n) begin model_reset(); return; end
    case (m_ph)
      0: if (req_valid != 0) begin
        n = lowbit(int'(req_valid));
        m_node = n; m_excl = req_excl[n]; m_line = req_line[n*LW +: LW];
        others = d_hold[m_line] & ~(1 << n);
        if (m_excl) begin m_pend = others; m_kind = 2; end
        else if (d_st[m_line] == 2) begin m_pend = others; m_kind = 3; end
        else m_pend = 0;
        m_ph = (m_pend != 0) ? 1 : 3;
        m_wcnt = 0;
      end
      1: m_ph = 2;
      2: begin
        m_pend = m_pend & ~int'(ack_valid);
        m_wcnt++;
        if (m_pend == 0) m_ph = 3;
      end
      default: begin
        if (m_excl) begin d_st[m_line] = 2; d_hold[m_line] = 1 << m_node; end
        else begin d_st[m_line] = 1; d_hold[m_line] |= 1 << m_node; end
        m_ph = 0;
      end
    endcase
  endtask

  task automatic tick();
    int acc;
    #1;
    check();
    acc = (m_ph == 0 && rst_n) ? lowbit(int'(req_valid)) : -1;
    @(posedge clk);
    model_step();
    cycles++;
    @(negedge clk);
    if (acc >= 0) req_valid[acc] = 1'b0;
    ack_valid = '0;
    if (m_ph == 2) begin
      if (m_wcnt >= 1 && m_pend != 0) ack_valid[lowbit(m_pend)] = 1'b1;
      if (m_wcnt == 0 && bogus >= 0) ack_valid[bogus] = 1'b1;
    end
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic post(input int n, input bit ex, input int line);
    req_valid[n] = 1'b1;
    req_excl[n]  = ex;
    req_line[n*LW +: LW] = LW'(line);
  endtask

  task automatic drain();
    for (int g = 0; g < 300; g++) begin
      if (m_ph == 0 && req_valid == '0) return;
      tick();
    end
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cycles = 0; bogus = -1;
    rst_n = 1'b0; req_valid = '0; req_excl = '0; req_line = '0; ack_valid = '0;
    model_reset(); m_line = 0;
    tag = "R1";
    @(negedge clk);
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (2) tick();

    // R1 R3: first reads to an Invalid line, then a second reader.
    tag = "R3"; post(1, 0, 5); drain();
    post(2, 0, 5); drain();

    // R4 R5: read-exclusive invalidates both sharers, one stray ack ignored.
    tag = "R4_R5"; bogus = 0; post(3, 1, 5); drain(); bogus = -1;

    // R8 R7: reader of the Modified line fetches from node 3 only.
    tag = "R7_R8"; post(0, 0, 5); drain();
    tag = "R4"; post(1, 1, 5); drain();

    // R6: sole holder upgrades; Invalid line granted at once.
    tag = "R6"; post(1, 1, 5); drain();
    post(2, 1, 9); drain();

    // R2 R9: simultaneous requests served lowest first, others held.
    tag = "R2_R9"; post(3, 0, 9); post(0, 1, 5); post(2, 0, 3); drain();

    // R9: request arriving while acks are pending waits.
    tag = "R9"; post(1, 1, 3); tick(); tick(); post(0, 0, 3); drain();

    // R10: line 7 untouched by the above; line 9 keeps its own holders.
    tag = "R10"; post(2, 1, 7); drain();
    post(1, 0, 9); drain();
    post(0, 1, 9); drain();

    // R5 R8: same-cycle multi-holder invalidation after mixed history.
    tag = "R5"; post(3, 0, 12); drain(); post(2, 0, 12); drain();
    post(1, 0, 12); drain(); post(0, 1, 12); drain();

    repeat (3) tick();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule